// File: doc/BRIEF.md
# Power-Supply Event Interrupt Controller

This block gathers power-management events into a single maskable interrupt line. It watches a supply-source select level that says whether the switched output supply currently comes from the main rail or the battery. A move in either direction is treated as an event. Four further event pulses arrive already synchronous to the block clock. They come from a supply-delta measurement engine, a battery-level monitor, a low-input comparator (which trips below 1.2 V) and a power-management status source.

Each event sets a sticky bit in a flag register, whether or not that bit is enabled. An enable register of the same layout chooses which set flags drive the interrupt output. Software uses a small register bus (address, write strobe, write data, combinational read data) to program the enables, to read the flags and to clear flags by writing 0. A read-only status register reports the synchronized supply source.

Register map: address 0 holds the flags, address 1 the enables and address 2 the status. Flag and enable bits share positions: 0 low-input, 1 battery switchover, 2 battery monitor, 3 supply delta, 6 management status, 7 supply restored. Bits 4 and 5 are reserved.

Top module: `pwr_evt_irq`

## Requirements
- R1: After reset the flag register (address 0), the enable register (address 1) and the status register (address 2) all read 0x00, and irq_o is low.
- R2: When the supply-source input falls from 1 (main) to 0 (battery), flag bit 1 becomes set on the third rising clock edge after the input changes. This is the battery-switchover event.
- R3: When the supply-source input rises from 0 to 1, flag bit 7 becomes set on the third rising clock edge after the input changes. This is the supply-restored event. The source is treated as battery (0) coming out of reset.
- R4: Bit 0 of the status register (address 2) shows the supply source after a two-flop synchronizer: 1 for main, 0 for battery. Bits 7..1 read 0.
- R5: A one-cycle pulse on evt_delta_i sets flag bit 3 on the next edge. A pulse on evt_bat_i sets flag bit 2 on the next edge.
- R6: A pulse on evt_low_i sets flag bit 0 on the next edge. A pulse on evt_psm_i sets flag bit 6 on the next edge.
- R7: Flags are set by their events regardless of the enable register. A flag whose enable bit is 0 does not raise irq_o.
- R8: irq_o equals the OR over all bit positions of (flag AND enable), taken from the current register contents with no added delay. It stays high until every enabled flag that is set has been cleared.
- R9: A write to address 0 clears each flag bit whose write-data bit is 0 and leaves unchanged each flag bit whose write-data bit is 1. Flags never clear in any other way. A write to address 1 loads the enable register.
- R10: If an event arrives in the same cycle that software clears its flag, the flag stays set.
- R11: Reserved bits 4 and 5 read 0 in both the flag and enable registers, even after writes of 1. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_main_i | input | 1 | Supply-source level, 1 = main, 0 = battery (asynchronous) |
| evt_low_i | input | 1 | Low-input comparator event pulse |
| evt_bat_i | input | 1 | Battery monitor event pulse |
| evt_delta_i | input | 1 | Supply-delta measurement event pulse |
| evt_psm_i | input | 1 | Power-management status event pulse |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The collision that matters most is a flag-clearing write that lands in the same cycle as that flag's event. A synchronized source edge can also be the event in such a collision. The bench forces this case on purpose by pulsing evt_bat_i together with a write of 0 to bit 2. It also times a clear onto the third edge after a source change. The flag must still read set afterwards. A behavioural reference model, written as a shift-history queue and integer masks, is compared with the read data and irq_o on every cycle. A long random phase then mixes writes, events and source toggles, so that collisions also appear unprompted.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;

   // register select codes on the bus
   localparam int unsigned REG_ADDR_W = 2;
   typedef enum logic [REG_ADDR_W-1:0] {
      SEL_FLAGS  = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   // count the bits that are 1 in a constant mask
   function automatic int unsigned pop_count(input logic [63:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 64; i++) begin
         n += int'(v[i]);
      end
      return n;
   endfunction

endpackage

// File: rtl/pwr_evt_sync.sv
module pwr_evt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwr_evt_sync: STAGES must be 2 or more");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_evt_edge.sv
module pwr_evt_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/pwr_evt_flags.sv
module pwr_evt_flags #(
   parameter int unsigned        WIDTH     = 8,
   parameter logic [WIDTH-1:0]   IMPL_MASK = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] flag_o
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pwr_evt_flags: WIDTH must be positive");
      end
   endgenerate

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic bit_q;
         // set has priority over clear; unimplemented positions stay 0
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) bit_q <= 1'b0;
            else         bit_q <= (set_i[b] | (bit_q & ~clr_i[b])) & IMPL_MASK[b];
         end
         assign flag_o[b] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/pwr_evt_irq.sv
module pwr_evt_irq #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BIT_LOW     = 0,
   parameter int unsigned BIT_BSO     = 1,
   parameter int unsigned BIT_BAT     = 2,
   parameter int unsigned BIT_DELTA   = 3,
   parameter int unsigned BIT_PSM     = 6,
   parameter int unsigned BIT_RST     = 7,
   parameter int unsigned STAT_BIT    = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              src_main_i,
   input  logic              evt_low_i,
   input  logic              evt_bat_i,
   input  logic              evt_delta_i,
   input  logic              evt_psm_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);
   import pwr_evt_pkg::*;

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
   localparam logic [DATA_W-1:0] IMPL_MASK =
      (ONE << BIT_LOW) | (ONE << BIT_BSO) | (ONE << BIT_BAT) |
      (ONE << BIT_DELTA) | (ONE << BIT_PSM) | (ONE << BIT_RST);
   localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(SEL_FLAGS);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(SEL_ENABLE);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(SEL_STATUS);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_dw
         $error("pwr_evt_irq: DATA_W out of range");
      end
      if (ADDR_W < REG_ADDR_W) begin : g_bad_aw
         $error("pwr_evt_irq: ADDR_W too small for the register map");
      end
      if (BIT_LOW >= DATA_W || BIT_BSO >= DATA_W || BIT_BAT >= DATA_W ||
          BIT_DELTA >= DATA_W || BIT_PSM >= DATA_W || BIT_RST >= DATA_W ||
          STAT_BIT >= DATA_W) begin : g_bad_pos
         $error("pwr_evt_irq: a bit position exceeds DATA_W");
      end
      if (pop_count(64'(IMPL_MASK)) != 6) begin : g_bad_dup
         $error("pwr_evt_irq: event bit positions must be distinct");
      end
   endgenerate

   // supply-source path
   logic src_sync;
   logic src_rise;
   logic src_fall;

   pwr_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (src_main_i),
      .q_o    (src_sync)
   );

   pwr_evt_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (src_sync),
      .rise_o (src_rise),
      .fall_o (src_fall)
   );

   // event vector in register layout
   logic [DATA_W-1:0] evt_vec;
   always_comb begin
      evt_vec            = '0;
      evt_vec[BIT_LOW]   = evt_low_i;
      evt_vec[BIT_BSO]   = src_fall;
      evt_vec[BIT_BAT]   = evt_bat_i;
      evt_vec[BIT_DELTA] = evt_delta_i;
      evt_vec[BIT_PSM]   = evt_psm_i;
      evt_vec[BIT_RST]   = src_rise;
   end

   // bus decode
   logic wr_flags;
   logic wr_enable;
   assign wr_flags  = bus_wr_i && (bus_addr_i == A_FLAGS);
   assign wr_enable = bus_wr_i && (bus_addr_i == A_ENABLE);

   logic [DATA_W-1:0] clr_vec;
   assign clr_vec = wr_flags ? ~bus_wdata_i : '0;

   logic [DATA_W-1:0] flag_q;
   pwr_evt_flags #(.WIDTH(DATA_W), .IMPL_MASK(IMPL_MASK)) u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_vec),
      .clr_i  (clr_vec),
      .flag_o (flag_q)
   );

   logic [DATA_W-1:0] en_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        en_q <= '0;
      else if (wr_enable) en_q <= bus_wdata_i & IMPL_MASK;
   end

   // read mux
   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         A_FLAGS:  bus_rdata_o = flag_q;
         A_ENABLE: bus_rdata_o = en_q;
         A_STATUS: bus_rdata_o[STAT_BIT] = src_sync;
         default:  bus_rdata_o = '0;
      endcase
   end

   assign irq_o = |(flag_q & en_q);
endmodule

// File: rtl/pwr_evt_irq_chk.sv
module pwr_evt_irq_chk #(
   parameter int unsigned      DATA_W    = 8,
   parameter int unsigned      ADDR_W    = 2,
   parameter int unsigned      BIT_BAT   = 2,
   parameter int unsigned      BIT_DELTA = 3,
   parameter logic [DATA_W-1:0] IMPL_MASK = '1,
   parameter logic [ADDR_W-1:0] A_FLAGS  = '0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              evt_bat_i,
   input logic              evt_delta_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_wr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic              irq_o,
   input logic [DATA_W-1:0] flag_q,
   input logic [DATA_W-1:0] en_q
);
   logic clr_bat;
   logic clr_delta;
   assign clr_bat   = bus_wr_i && (bus_addr_i == A_FLAGS) && !bus_wdata_i[BIT_BAT];
   assign clr_delta = bus_wr_i && (bus_addr_i == A_FLAGS) && !bus_wdata_i[BIT_DELTA];

   p_bat_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_bat_i |=> flag_q[BIT_BAT]);

   p_delta_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[BIT_DELTA]) |-> $past(evt_delta_i));

   p_sticky_bat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[BIT_BAT] && !clr_bat) |=> flag_q[BIT_BAT]);

   p_clear_delta_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_delta && !evt_delta_i) |=> !flag_q[BIT_DELTA]);

   p_event_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_bat && evt_bat_i) |=> flag_q[BIT_BAT]);

   p_irq_raised_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[BIT_BAT] && en_q[BIT_BAT]) |-> irq_o);

   p_irq_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flag_q & en_q) == '0) |-> !irq_o);

   p_reserved_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((flag_q | en_q) & ~IMPL_MASK) == '0));
endmodule

bind pwr_evt_irq pwr_evt_irq_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .BIT_BAT   (BIT_BAT),
   .BIT_DELTA (BIT_DELTA),
   .IMPL_MASK (IMPL_MASK),
   .A_FLAGS   (A_FLAGS)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .evt_bat_i   (evt_bat_i),
   .evt_delta_i (evt_delta_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wr_i    (bus_wr_i),
   .bus_wdata_i (bus_wdata_i),
   .irq_o       (irq_o),
   .flag_q      (flag_q),
   .en_q        (en_q)
);

// File: tb/sim_pwr_evt_irq.sv
module sim_pwr_evt_irq;
   localparam time CLK_P = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       src = 1'b0;
   logic       e_low = 1'b0, e_bat = 1'b0, e_delta = 1'b0, e_psm = 1'b0;
   logic [1:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   int n_tests = 0;
   int n_fail  = 0;

   // reference model state
   bit       hist[$];
   bit [7:0] m_flag = 8'h00;
   bit [7:0] m_en   = 8'h00;
   localparam bit [7:0] MASK = 8'hCF;

   always #(CLK_P/2) clk = ~clk;

   pwr_evt_irq u0 (
      .clk_i(clk), .rst_ni(rst_n), .src_main_i(src),
      .evt_low_i(e_low), .evt_bat_i(e_bat), .evt_delta_i(e_delta), .evt_psm_i(e_psm),
      .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq)
   );

   function automatic bit [7:0] model_read(input bit [1:0] a);
      case (a)
         2'd0:    return m_flag;
         2'd1:    return m_en;
         2'd2:    return {7'b0, hist[1]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic check8(input string req, input bit [7:0] act, input bit [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: read data 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check1(input string req, input logic act, input bit exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: irq %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, compare, then advance the model to the next edge
   task automatic step(input string req, input bit [1:0] a, input bit w, input bit [7:0] d,
                       input bit s, input bit [3:0] ev);
      bit [7:0] evv;
      bit [7:0] clr;
      bit s2, s3;
      @(negedge clk);
      addr = a; wr = w; wdata = d; src = s;
      e_low = ev[0]; e_bat = ev[1]; e_delta = ev[2]; e_psm = ev[3];
      #1;
      check8(req, rdata, model_read(a));
      check1(req, irq, |(m_flag & m_en));
      s2 = hist[1]; s3 = hist[2];
      evv = 8'h00;
      evv[0] = ev[0]; evv[1] = !s2 && s3; evv[2] = ev[1];
      evv[3] = ev[2]; evv[6] = ev[3];     evv[7] = s2 && !s3;
      clr = (w && a == 2'd0) ? ~d : 8'h00;
      m_flag = ((m_flag & ~clr) | evv) & MASK;
      if (w && a == 2'd1) m_en = d & MASK;
      hist.push_front(s);
      void'(hist.pop_back());
   endtask

   task automatic idle(input string req, input bit [1:0] a, input bit s, input int n);
      for (int i = 0; i < n; i++) step(req, a, 1'b0, 8'h00, s, 4'h0);
   endtask

   initial begin
      hist = '{0, 0, 0};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      idle("R1", 2'd0, 1'b0, 1);
      idle("R1", 2'd1, 1'b0, 1);
      idle("R1", 2'd2, 1'b0, 1);
      // R5 measurement events
      step("R5", 2'd0, 0, 8'h00, 0, 4'b0100);
      idle("R5", 2'd0, 1'b0, 1);
      step("R5", 2'd0, 0, 8'h00, 0, 4'b0010);
      idle("R5", 2'd0, 1'b0, 1);
      // R6 low-input and management events
      step("R6", 2'd0, 0, 8'h00, 0, 4'b0001);
      step("R6", 2'd0, 0, 8'h00, 0, 4'b1000);
      idle("R6", 2'd0, 1'b0, 1);
      // R7 flags set while all enables are 0, irq stays low
      idle("R7", 2'd1, 1'b0, 2);
      // R9 writing ones changes nothing, a zero clears one bit
      step("R9", 2'd0, 1, 8'hFF, 0, 4'h0);
      step("R9", 2'd0, 1, 8'hF7, 0, 4'h0);
      idle("R9", 2'd0, 1'b0, 1);
      // R8 enable battery monitor bit, irq follows, clear drops it
      step("R8", 2'd1, 1, 8'h04, 0, 4'h0);
      idle("R8", 2'd0, 1'b0, 1);
      step("R8", 2'd0, 1, 8'hFB, 0, 4'h0);
      idle("R8", 2'd0, 1'b0, 1);
      // R10 event in the clearing cycle
      step("R10", 2'd0, 1, 8'hFB, 0, 4'b0010);
      idle("R10", 2'd0, 1'b0, 2);
      // R3 and R4 supply restored
      step("R3", 2'd2, 0, 8'h00, 1, 4'h0);
      idle("R4", 2'd2, 1'b1, 3);
      idle("R3", 2'd0, 1'b1, 2);
      step("R3", 2'd1, 1, 8'h82, 1, 4'h0);
      idle("R8", 2'd0, 1'b1, 1);
      step("R9", 2'd0, 1, 8'h00, 1, 4'h0);
      // R2 battery switchover, clear lands on the setting edge (R10)
      step("R2", 2'd2, 0, 8'h00, 0, 4'h0);
      idle("R4", 2'd2, 1'b0, 1);
      step("R10", 2'd0, 1, 8'h00, 0, 4'h0);
      idle("R2", 2'd0, 1'b0, 2);
      // R11 reserved bits and unmapped address
      step("R11", 2'd1, 1, 8'hFF, 0, 4'h0);
      idle("R11", 2'd1, 1'b0, 1);
      idle("R11", 2'd3, 1'b0, 1);
      step("R11", 2'd0, 1, 8'hFF, 0, 4'hF);
      idle("R11", 2'd0, 1'b0, 1);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         bit s_r;
         s_r = ($urandom_range(0, 9) == 0) ? ~hist[0] : hist[0];
         step("R8", 2'($urandom_range(0, 3)), ($urandom_range(0, 2) == 0),
              8'($urandom), s_r, 4'($urandom & $urandom));
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule